// File: doc/BRIEF.md
# SDLC Receive Address Filter

The filter sits between an SDLC deframing stage and the receive FIFO. It watches the byte stream coming out of flag detection and decides, one frame at a time, whether the bytes of that frame reach the FIFO. The first byte after the opening flag is the station address. When filtering is switched on, a frame is kept only if that address equals a programmed 8-bit value or is the all-ones broadcast address. A frame that fails the test is discarded up to the next opening flag. When filtering is off, every frame is forwarded.

Software may rewrite the compare value and the enable bit at any moment, including in the middle of a frame. The filter copies both into shadow registers when a frame starts, so a write only affects the frames that open after it. The compare value has no defined reset content and must be programmed before the receiver is switched on.

Upstream signalling uses a one-cycle `rxSof` pulse for the opening flag. Bytes arrive on `rxValid`/`rxByte`. `rxEof` is qualified by `rxValid` and marks the final byte. `rxAbort` is a one-cycle pulse with no data. Each accepted byte appears on the FIFO write port one clock after it is presented, and the last byte of a frame carries an end tag.

Top module: `sdlc_addr_filter`

## Requirements
- R1: After reset `fifoWrEn` and `fifoEof` are 0, and bytes presented before any `rxSof` produce no FIFO write.
- R2: With the enable sampled at start of frame equal to 0, every byte of the frame is written, whatever its address.
- R3: With filtering enabled and the first byte equal to the sampled compare value, that byte and every later byte of the frame are written in arrival order.
- R4: With filtering enabled and an address that matches neither the compare value nor 0xFF, no byte of that frame is written until the next `rxSof`.
- R5: With filtering enabled, an address byte of 0xFF is accepted whatever the compare value.
- R6: The compare value and the enable are sampled on the cycle that `rxSof` is high. Changes made later in a frame do not alter the decision for that frame, and they apply from the next frame.
- R7: `fifoEof` is 1 only on the write that carries a byte presented with `rxEof` in an accepted frame. A one-byte accepted frame gets the tag on its address byte.
- R8: `rxAbort` ends the current frame with no write. This covers an abort before the address byte. Later bytes are ignored until the next `rxSof`.
- R9: `rxSof` restarts evaluation in any state, so the next valid byte is treated as an address. A byte presented in the same cycle as `rxSof` or `rxAbort` is not written.
- R10: An accepted byte presented at clock edge k shows up on `fifoData` with `fifoWrEn` high right after edge k. No write occurs in a cycle that follows one with no valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A received byte is present on `rxByte` |
| rxByte | input | 8 | Received byte |
| rxSof | input | 1 | Opening flag seen, new frame starts (one cycle) |
| rxEof | input | 1 | Qualified by `rxValid`: this byte is the last of the frame |
| rxAbort | input | 1 | Frame aborted (one cycle, no data) |
| cfgMatchVal | input | 8 | Programmed address compare value |
| cfgMatchEn | input | 1 | Address filtering enable |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoData | output | 8 | Byte to write |
| fifoEof | output | 1 | The written byte closes its frame |

## Verification
A control state that stays in the forwarding state after a rejected address, or in the dropping state after a match, shows up on the very next valid byte. Either a write appears where none was due or an expected write is missing. A stale or freshly loaded shadow register changes the decision on the first address byte after an `rxSof` that arrives during a configuration change. A wrong end tag shows up on the write of the final byte. None of these faults needs more than one frame to appear at the ports.

// File: rtl/sdlc_filt_pkg.sv
package sdlc_filt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_PASS = 2'd2,
    ST_DROP = 2'd3
  } filtState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadShadow;
    logic writeByte;
    logic tagEof;
  } filtStrobe_t;

endpackage

// File: rtl/sdlc_filt_ctrl.sv
module sdlc_filt_ctrl
  import sdlc_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic        rxAbort,
  input  logic        addrHit,
  output filtStrobe_t strobe,
  output filtState_t  state
);

  filtState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (rxSof) begin
      // Opening flag wins over everything; a byte in this cycle is dropped.
      nextState         = ST_ADDR;
      strobe.loadShadow = 1'b1;
    end else if (rxAbort) begin
      nextState = ST_IDLE;
    end else if (rxValid) begin
      unique case (state)
        ST_IDLE: nextState = ST_IDLE;
        ST_ADDR: begin
          if (addrHit) begin
            strobe.writeByte = 1'b1;
            strobe.tagEof    = rxEof;
            nextState        = rxEof ? ST_IDLE : ST_PASS;
          end else begin
            nextState = rxEof ? ST_IDLE : ST_DROP;
          end
        end
        ST_PASS: begin
          strobe.writeByte = 1'b1;
          strobe.tagEof    = rxEof;
          if (rxEof) nextState = ST_IDLE;
        end
        ST_DROP: begin
          if (rxEof) nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/sdlc_filt_dp.sv
module sdlc_filt_dp
  import sdlc_filt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtStrobe_t       strobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] cfgMatchVal,
  input  logic              cfgMatchEn,
  output logic              addrHit,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoEof
);

  localparam logic [DATA_W-1:0] BCAST_ADDR = {DATA_W{1'b1}};

  logic [DATA_W-1:0] matchShadow;
  logic              enShadow;
  logic              exactHit;
  logic              bcastHit;

  // Configuration is frozen for the whole frame at its opening flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchShadow <= '0;
      enShadow    <= 1'b0;
    end else if (strobe.loadShadow) begin
      matchShadow <= cfgMatchVal;
      enShadow    <= cfgMatchEn;
    end
  end

  assign exactHit = (rxByte == matchShadow);

  generate
    if (BCAST_EN) begin : g_bcast
      assign bcastHit = (rxByte == BCAST_ADDR);
    end else begin : g_noBcast
      assign bcastHit = 1'b0;
    end
  endgenerate

  assign addrHit = !enShadow || exactHit || bcastHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWrEn <= 1'b0;
      fifoEof  <= 1'b0;
      fifoData <= '0;
    end else begin
      fifoWrEn <= strobe.writeByte;
      fifoEof  <= strobe.writeByte && strobe.tagEof;
      if (strobe.writeByte) fifoData <= rxByte;
    end
  end

endmodule

// File: rtl/sdlc_addr_filter.sv
module sdlc_addr_filter
  import sdlc_filt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxSof,
  input  logic              rxEof,
  input  logic              rxAbort,
  input  logic [DATA_W-1:0] cfgMatchVal,
  input  logic              cfgMatchEn,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoEof
);

  filtStrobe_t ctlStrobe;
  filtState_t  ctlState;
  logic        addrHit;

  sdlc_filt_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxSof   (rxSof),
    .rxEof   (rxEof),
    .rxAbort (rxAbort),
    .addrHit (addrHit),
    .strobe  (ctlStrobe),
    .state   (ctlState)
  );

  sdlc_filt_dp #(.DATA_W(DATA_W), .BCAST_EN(1'b1)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (ctlStrobe),
    .rxByte      (rxByte),
    .cfgMatchVal (cfgMatchVal),
    .cfgMatchEn  (cfgMatchEn),
    .addrHit     (addrHit),
    .fifoWrEn    (fifoWrEn),
    .fifoData    (fifoData),
    .fifoEof     (fifoEof)
  );

endmodule

// File: rtl/sdlc_addr_filter_chk.sv
module sdlc_addr_filter_chk
  import sdlc_filt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxByte,
  input logic              rxSof,
  input logic              rxEof,
  input logic              rxAbort,
  input logic              fifoWrEn,
  input logic [DATA_W-1:0] fifoData,
  input logic              fifoEof,
  input filtState_t        ctlState
);

  a_r10_write_needs_byte: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(rxValid && !rxSof && !rxAbort));

  a_r10_data_echo: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (fifoData == $past(rxByte)));

  a_r7_eof_on_last_write: assert property (@(posedge clk) disable iff (!rstN)
    fifoEof |-> (fifoWrEn && $past(rxEof)));

  a_r8_abort_no_write: assert property (@(posedge clk) disable iff (!rstN)
    rxAbort |=> !fifoWrEn);

  a_r9_sof_rearms: assert property (@(posedge clk) disable iff (!rstN)
    rxSof |=> (ctlState == ST_ADDR && !fifoWrEn));

  a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_DROP) |=> !fifoWrEn);

  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_IDLE) |=> !fifoWrEn);

endmodule

bind sdlc_addr_filter sdlc_addr_filter_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .rxValid  (rxValid),
  .rxByte   (rxByte),
  .rxSof    (rxSof),
  .rxEof    (rxEof),
  .rxAbort  (rxAbort),
  .fifoWrEn (fifoWrEn),
  .fifoData (fifoData),
  .fifoEof  (fifoEof),
  .ctlState (ctlState)
);

// File: tb/sdlc_addr_filter_tb_top.sv
`timescale 1ns/1ps
module sdlc_addr_filter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       rxSof = 1'b0;
  logic       rxEof = 1'b0;
  logic       rxAbort = 1'b0;
  logic [7:0] cfgMatchVal = 8'h00;
  logic       cfgMatchEn = 1'b0;
  logic       fifoWrEn;
  logic [7:0] fifoData;
  logic       fifoEof;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  // Bench model: 0 idle, 1 addr, 2 pass, 3 drop.
  int         mState = 0;
  logic [7:0] mVal = 8'h00;
  bit         mEn = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sdlc_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .rxSof(rxSof), .rxEof(rxEof), .rxAbort(rxAbort),
    .cfgMatchVal(cfgMatchVal), .cfgMatchEn(cfgMatchEn),
    .fifoWrEn(fifoWrEn), .fifoData(fifoData), .fifoEof(fifoEof)
  );

  function automatic bit addrAccepted(logic [7:0] a, logic [7:0] v, bit en);
    return !en || (a == v) || (a == 8'hFF);
  endfunction

  task automatic compare(bit expWr, logic [7:0] expData, bit expEof, string tag);
    vecCount++;
    if (fifoWrEn !== expWr ||
        (expWr && fifoData !== expData) ||
        fifoEof !== (expWr && expEof)) begin
      failCount++;
      $display("FAIL %s: wr=%0b data=%02h eof=%0b expected wr=%0b data=%02h eof=%0b",
               tag, fifoWrEn, fifoData, fifoEof, expWr, expData, expWr && expEof);
    end
  endtask

  // One cycle of stimulus: drive at negedge, update model, check after posedge.
  task automatic step(bit sof, bit vld, logic [7:0] b, bit eof, bit abt, string ovr);
    bit   expWr = 1'b0;
    bit   expEof = 1'b0;
    string tag = "R10";
    @(negedge clk);
    rxSof = sof; rxValid = vld; rxByte = b; rxEof = eof; rxAbort = abt;
    if (sof) begin
      mState = 1; mVal = cfgMatchVal; mEn = cfgMatchEn; tag = "R9";
    end else if (abt) begin
      mState = 0; tag = "R8";
    end else if (vld) begin
      case (mState)
        0: tag = "R1";
        1: begin
          if (addrAccepted(b, mVal, mEn)) begin
            expWr = 1'b1; expEof = eof;
            tag = !mEn ? "R2" : (b == mVal) ? "R3" : "R5";
            if (eof) tag = "R7";
            mState = eof ? 0 : 2;
          end else begin
            tag = "R4"; mState = eof ? 0 : 3;
          end
        end
        2: begin
          expWr = 1'b1; expEof = eof; tag = eof ? "R7" : "R3";
          if (eof) mState = 0;
        end
        default: begin
          tag = "R4";
          if (eof) mState = 0;
        end
      endcase
    end
    if (ovr != "") tag = ovr;
    @(posedge clk);
    #5;
    compare(expWr, b, expEof, tag);
  endtask

  task automatic frame(logic [7:0] addr, int len, string ovr);
    step(1, 0, 8'h00, 0, 0, ovr);
    for (int i = 0; i < len; i++)
      step(0, 1, (i == 0) ? addr : 8'(8'h30 + i), (i == len - 1), 0, ovr);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      failCount++;
      $display("FAIL R10: watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #5;
    compare(0, 8'h00, 0, "R1");  // outputs quiet during reset
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #5;
    compare(0, 8'h00, 0, "R1");

    // R1: bytes before any opening flag are ignored
    step(0, 1, 8'hFF, 0, 0, "R1");
    step(0, 1, 8'h12, 1, 0, "R1");

    // R2: filtering off, foreign address forwarded
    cfgMatchVal = 8'h34; cfgMatchEn = 1'b0;
    frame(8'h12, 4, "R2");

    // R3: exact match
    cfgMatchEn = 1'b1;
    frame(8'h34, 5, "");

    // R4: mismatch, whole frame dropped
    frame(8'h35, 5, "R4");

    // R5: broadcast with an unrelated compare value
    cfgMatchVal = 8'h55;
    frame(8'hFF, 3, "R5");

    // R7: single-byte accepted frame, tag on the address write
    frame(8'h55, 1, "R7");

    // R6: mid-frame rewrite does not affect current frame
    cfgMatchVal = 8'h10;
    step(1, 0, 8'h00, 0, 0, "R6");
    cfgMatchVal = 8'h99; cfgMatchEn = 1'b1;
    step(0, 1, 8'h10, 0, 0, "R6");
    cfgMatchVal = 8'h77;
    step(0, 1, 8'hAB, 0, 0, "R6");
    step(0, 1, 8'hCD, 1, 0, "R6");
    frame(8'h10, 2, "R6");  // old value no longer matches
    frame(8'h77, 2, "R6");  // new value applies
    cfgMatchEn = 1'b1; cfgMatchVal = 8'h01;
    step(1, 0, 8'h00, 0, 0, "R6");
    cfgMatchEn = 1'b0;      // disabling mid-frame has no effect now
    step(0, 1, 8'h02, 0, 0, "R6");
    step(0, 1, 8'h03, 1, 0, "R6");

    // R8: abort before address, then abort in the middle of a passing frame
    cfgMatchEn = 1'b1; cfgMatchVal = 8'h22;
    step(1, 0, 8'h00, 0, 0, "R8");
    step(0, 0, 8'h00, 0, 1, "R8");
    step(0, 1, 8'h22, 0, 0, "R8");
    step(1, 0, 8'h00, 0, 0, "R8");
    step(0, 1, 8'h22, 0, 0, "R8");
    step(0, 1, 8'h44, 0, 1, "R8");  // byte with abort is not written
    step(0, 1, 8'h45, 0, 0, "R8");
    step(0, 1, 8'h46, 1, 0, "R8");

    // R9: opening flag in the middle of dropping and passing frames
    step(1, 0, 8'h00, 0, 0, "R9");
    step(0, 1, 8'h23, 0, 0, "R9");
    step(1, 1, 8'h22, 0, 0, "R9");  // byte alongside the flag is dropped
    step(0, 1, 8'h22, 0, 0, "R9");
    step(0, 1, 8'h60, 0, 0, "R9");
    step(1, 0, 8'h00, 0, 0, "R9");
    step(0, 1, 8'h61, 0, 0, "R9");  // new address, mismatches
    step(0, 1, 8'h62, 1, 0, "R9");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      logic [7:0] b = 8'($urandom);
      if ($urandom_range(0, 29) == 0) cfgMatchVal = 8'($urandom_range(0, 3));
      if ($urandom_range(0, 39) == 0) cfgMatchEn = 1'($urandom);
      if (mState == 1) begin
        int k = $urandom_range(0, 3);
        b = (k == 0) ? 8'hFF : (k == 1) ? mVal : 8'($urandom_range(0, 3));
      end
      if (r < 10)      step(1, 0, 8'h00, 0, 0, "");
      else if (r < 13) step(0, 0, 8'h00, 0, 1, "");
      else if (r < 25) step(0, 0, b, 0, 0, "");
      else             step(0, 1, b, ($urandom_range(0, 5) == 0), 0, "");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule